// File: doc/BRIEF.md
# Insertion Sorter for Partial Products

The block keeps a bounded set of partial products, each a column index with a value attached, in ascending column order while they arrive in any order. It is a chain of storage slots, and every slot has its own comparator. When an item arrives, all occupied slots compare their key with the new key in the same cycle. The item is written at the first slot whose key is larger, and every slot from that point on moves one place towards the tail. An empty slot counts as larger than any key, so the stored entries always form a sorted prefix of the chain.

When the row of partial products is complete, a flush command turns the block into a source. It hands the stored entries, smallest column first, to a downstream merge stage over a valid/ready handshake. It flags the final entry, and it leaves every slot empty when it finishes. The block does not accept new items while it drains. Equal keys are not combined here; combining them is the job of the merge stage.

Top module: `psort_insertion_sorter`

## Requirements
- R1: After reset every slot is empty: `full`=0, `out_valid`=0, `draining`=0 and `in_ready`=1.
- R2: Entries leave in non-decreasing key order, and each value leaves together with the key it arrived with. Key 0 and the largest key (all ones) are handled like any other key, and the largest key still sorts ahead of empty slots.
- R3: An item is accepted on every clock edge where `in_valid` and `in_ready` are both high, so back-to-back arrivals need no idle cycles.
- R4: Items with equal keys leave in the order they arrived.
- R5: Once all DEPTH slots hold entries, `full` is 1 and `in_ready` is 0. An item offered in that state is not stored.
- R6: After a flush, one entry is transferred on each edge where `out_valid` and `out_ready` are both high. `out_last` is 1 only with the final entry. While `out_ready` is 0, the presented entry is held unchanged.
- R7: While `draining` is 1, `in_ready` is 0, and an item offered at the input is not stored.
- R8: The cycle after the final entry is transferred, `draining` and `out_valid` are 0, `full` is 0 and `in_ready` is 1. A following flush produces no output.
- R9: A flush while the block is empty produces no output. The block spends one cycle with `draining`=1 and then accepts input again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An item is offered at the input |
| in_key | input | KEY_W | Column index of the offered item |
| in_val | input | VAL_W | Value of the offered item |
| in_ready | output | 1 | The offered item is taken on this edge |
| full | output | 1 | Every slot holds an entry |
| flush | input | 1 | Start handing out the stored entries |
| draining | output | 1 | The block is in its output phase |
| out_valid | output | 1 | An entry is presented at the output |
| out_key | output | KEY_W | Column index of the presented entry |
| out_val | output | VAL_W | Value of the presented entry |
| out_last | output | 1 | The presented entry is the final one |
| out_ready | input | 1 | The downstream stage takes the presented entry |

## Verification
The sorting function is driven with a strictly descending sequence, which makes every arrival insert at slot 0 and shift the whole chain. It is also driven with a scrambled sequence full of repeated keys, which exercises insertion in the middle of the chain and shows whether equal keys keep their arrival order. A complete fill to DEPTH entries, including the extreme keys 0 and all ones, followed by offers made while full, separates a correct insertion point from an off-by-one shift at the tail. Drains are run both with `out_ready` held high and with periodic stalls, and with items offered mid-drain, so that lost, duplicated or wrongly accepted entries show up in the output stream.

// File: rtl/psort_pkg.sv
// Shared definitions for the insertion sorter.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package psort_pkg;

    // Operating phase of the sorter.
    typedef enum logic {
        PS_FILL  = 1'b0,
        PS_DRAIN = 1'b1
    } psort_mode_e;

endpackage

// File: rtl/psort_pos_finder.sv
// Finds where a new key belongs in the sorted chain.
// Every slot compares its key with the new key at once. A slot is "after" the
// new item when it is empty or holds a strictly larger key, so equal keys stay
// ahead of the new item. Assumes the occupied slots form a sorted prefix, which
// makes the "after" vector a thermometer code.
module psort_pos_finder #(
    parameter int DEPTH = 32,
    parameter int KEY_W = 16
) (
    input  logic [DEPTH-1:0]            slot_vld,
    input  logic [DEPTH-1:0][KEY_W-1:0] slot_key,
    input  logic [KEY_W-1:0]            new_key,
    output logic [DEPTH-1:0]            take_new,
    output logic [DEPTH-1:0]            take_prev
);

    logic [DEPTH-1:0] after_new;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        // Per-slot comparator: empty slots count as larger than any key.
        assign after_new[i] = !slot_vld[i] || (slot_key[i] > new_key);

        if (i == 0) begin : g_head
            // The head slot takes the new item when it lies after it.
            assign take_new[i]  = after_new[i];
            assign take_prev[i] = 1'b0;
        end else begin : g_body
            // First slot after the new item takes it; later ones shift along.
            assign take_new[i]  = after_new[i] && !after_new[i-1];
            assign take_prev[i] = after_new[i] &&  after_new[i-1];
        end
    end

endmodule

// File: rtl/psort_slot.sv
// One storage slot of the sorter: a valid flag, a key and a value.
// It loads the new item, its upstream neighbour (insert shift) or its
// downstream neighbour (drain shift). Assumes at most one load is active.
module psort_slot #(
    parameter int KEY_W = 16,
    parameter int VAL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_new,
    input  logic             ld_prev,
    input  logic             ld_next,
    input  logic [KEY_W-1:0] new_key,
    input  logic [VAL_W-1:0] new_val,
    input  logic             prev_vld,
    input  logic [KEY_W-1:0] prev_key,
    input  logic [VAL_W-1:0] prev_val,
    input  logic             next_vld,
    input  logic [KEY_W-1:0] next_key,
    input  logic [VAL_W-1:0] next_val,
    output logic             q_vld,
    output logic [KEY_W-1:0] q_key,
    output logic [VAL_W-1:0] q_val
);

    // Slot register: reset to empty, then take the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= 1'b0;
            q_key <= '0;
            q_val <= '0;
        end else if (ld_new) begin
            q_vld <= 1'b1;
            q_key <= new_key;
            q_val <= new_val;
        end else if (ld_prev) begin
            q_vld <= prev_vld;
            q_key <= prev_key;
            q_val <= prev_val;
        end else if (ld_next) begin
            q_vld <= next_vld;
            q_key <= next_key;
            q_val <= next_val;
        end
    end

endmodule

// File: rtl/psort_ctrl.sv
// Phase control of the sorter: fill phase until a flush, then drain phase
// until the final entry leaves or the head slot is found empty.
// Assumes head_vld and head_last describe slot 0.
module psort_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic head_vld,
    input  logic head_last,
    input  logic out_ready,
    output psort_pkg::psort_mode_e mode
);
    import psort_pkg::*;

    psort_mode_e mode_nxt;

    // Next-phase decision.
    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            PS_FILL:  if (flush) mode_nxt = PS_DRAIN;
            PS_DRAIN: if (!head_vld || (out_ready && head_last)) mode_nxt = PS_FILL;
            default:  mode_nxt = PS_FILL;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= PS_FILL;
        else        mode <= mode_nxt;
    end

endmodule

// File: rtl/psort_insertion_sorter.sv
// Shift-register insertion sorter for (column index, value) partial products.
// Fill phase: one item per cycle is inserted in ascending key order; equal
// keys keep arrival order. Drain phase (after flush): entries leave from
// slot 0 one per handshake while the chain shifts towards the head.
// Assumes DEPTH >= 2.
module psort_insertion_sorter #(
    parameter int DEPTH = 32,
    parameter int KEY_W = 16,
    parameter int VAL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [KEY_W-1:0] in_key,
    input  logic [VAL_W-1:0] in_val,
    output logic             in_ready,
    output logic             full,
    input  logic             flush,
    output logic             draining,
    output logic             out_valid,
    output logic [KEY_W-1:0] out_key,
    output logic [VAL_W-1:0] out_val,
    output logic             out_last,
    input  logic             out_ready
);
    import psort_pkg::*;

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0]            slot_vld;
    logic [DEPTH-1:0][KEY_W-1:0] slot_key;
    logic [DEPTH-1:0][VAL_W-1:0] slot_val;
    logic [DEPTH-1:0]            pos_new, pos_prev;
    logic                        do_ins, do_pop;
    psort_mode_e                 mode;

    psort_pos_finder #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_find (
        .slot_vld  (slot_vld),
        .slot_key  (slot_key),
        .new_key   (in_key),
        .take_new  (pos_new),
        .take_prev (pos_prev)
    );

    psort_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .head_vld  (slot_vld[0]),
        .head_last (out_last),
        .out_ready (out_ready),
        .mode      (mode)
    );

    // Handshake and status decode.
    always_comb begin
        draining  = (mode == PS_DRAIN);
        full      = slot_vld[LAST];
        in_ready  = !draining && !full;
        do_ins    = in_valid && in_ready;
        out_valid = draining && slot_vld[0];
        do_pop    = out_valid && out_ready;
        out_key   = slot_key[0];
        out_val   = slot_val[0];
        out_last  = slot_vld[0] && !slot_vld[1];
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic             p_vld, n_vld;
        logic [KEY_W-1:0] p_key, n_key;
        logic [VAL_W-1:0] p_val, n_val;

        if (i == 0) begin : g_up_head
            assign p_vld = 1'b0;
            assign p_key = '0;
            assign p_val = '0;
        end else begin : g_up_body
            assign p_vld = slot_vld[i-1];
            assign p_key = slot_key[i-1];
            assign p_val = slot_val[i-1];
        end

        if (i == LAST) begin : g_dn_tail
            assign n_vld = 1'b0;
            assign n_key = '0;
            assign n_val = '0;
        end else begin : g_dn_body
            assign n_vld = slot_vld[i+1];
            assign n_key = slot_key[i+1];
            assign n_val = slot_val[i+1];
        end

        psort_slot #(.KEY_W(KEY_W), .VAL_W(VAL_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_new   (do_ins && pos_new[i]),
            .ld_prev  (do_ins && pos_prev[i]),
            .ld_next  (do_pop),
            .new_key  (in_key),
            .new_val  (in_val),
            .prev_vld (p_vld),
            .prev_key (p_key),
            .prev_val (p_val),
            .next_vld (n_vld),
            .next_key (n_key),
            .next_val (n_val),
            .q_vld    (slot_vld[i]),
            .q_key    (slot_key[i]),
            .q_val    (slot_val[i])
        );
    end

endmodule

// File: rtl/psort_checker.sv
// Protocol checker for the insertion sorter, attached by bind.
// Relates the top-level ports over time; assumes the bench keeps rst_n low
// for at least one edge at start.
module psort_checker #(
    parameter int KEY_W = 16,
    parameter int VAL_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             full,
    input logic             flush,
    input logic             draining,
    input logic             out_valid,
    input logic [KEY_W-1:0] out_key,
    input logic [VAL_W-1:0] out_val,
    input logic             out_last,
    input logic             out_ready
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !full && !draining && in_ready)); // R1

    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && out_key >= $past(out_key))); // R2

    AST_FILL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!draining && !full) |-> in_ready); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !in_ready); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_key) && $stable(out_val) && $stable(out_last))); // R6

    AST_DRAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        draining |-> !in_ready); // R7

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!draining && !out_valid && !full)); // R8

    AST_EMPTY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && !out_valid) |=> !draining); // R9

    AST_OUT_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> draining); // R6

    // Input signals observed for completeness of the bound view.
    AST_IN_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({in_valid, flush, out_ready})); // R3

endmodule

bind psort_insertion_sorter psort_checker #(.KEY_W(KEY_W), .VAL_W(VAL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .full      (full),
    .flush     (flush),
    .draining  (draining),
    .out_valid (out_valid),
    .out_key   (out_key),
    .out_val   (out_val),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/tb_psort_insertion_sorter.sv
// Directed bench for the insertion sorter. Inputs change on the falling edge,
// outputs are sampled on the falling edge. A queue model keeps the expected
// order: stable insertion by key.
module tb_psort_insertion_sorter;

    localparam int DEPTH = 32;
    localparam int KEY_W = 16;
    localparam int VAL_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [KEY_W-1:0] in_key = '0;
    logic [VAL_W-1:0] in_val = '0;
    logic             in_ready, full, draining;
    logic             flush = 1'b0;
    logic             out_valid, out_last;
    logic [KEY_W-1:0] out_key;
    logic [VAL_W-1:0] out_val;
    logic             out_ready = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [KEY_W-1:0] mk[$];
    logic [VAL_W-1:0] mv[$];

    always #4 clk = ~clk;

    psort_insertion_sorter #(.DEPTH(DEPTH), .KEY_W(KEY_W), .VAL_W(VAL_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_key(in_key), .in_val(in_val), .in_ready(in_ready),
        .full(full), .flush(flush), .draining(draining),
        .out_valid(out_valid), .out_key(out_key), .out_val(out_val),
        .out_last(out_last), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Stable insertion into the model: after all keys <= the new key.
    task automatic model_insert(input logic [KEY_W-1:0] k, input logic [VAL_W-1:0] v);
        int pos = mk.size();
        for (int j = 0; j < mk.size(); j++) begin
            if (mk[j] > k) begin pos = j; break; end
        end
        mk.insert(pos, k);
        mv.insert(pos, v);
    endtask

    // Offer one item for one cycle; starts and ends on a falling edge.
    task automatic push(input logic [KEY_W-1:0] k, input logic [VAL_W-1:0] v, input string req);
        in_valid = 1'b1;
        in_key   = k;
        in_val   = v;
        #0;
        check(in_ready === 1'b1, req, "in_ready while filling", in_ready, 1);
        if (in_ready) model_insert(k, v);
        @(negedge clk);
    endtask

    // Flush and compare the whole output stream with the model.
    task automatic drain_expect(input int stall_every, input bit inject, input string req);
        int idx = 0;
        int guard = 0;
        bit done = 1'b0;
        in_valid = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        while (!done && guard < 4 * DEPTH + 10) begin
            check(out_valid === 1'b1, req, "out_valid during drain", out_valid, 1);
            check(in_ready === 1'b0, "R7", "in_ready during drain", in_ready, 0);
            check(out_key === mk[idx], req, $sformatf("key at position %0d", idx), out_key, mk[idx]);
            check(out_val === mv[idx], req, $sformatf("value at position %0d", idx), out_val, mv[idx]);
            check(out_last === (idx == mk.size() - 1), "R6", "out_last flag",
                  out_last, (idx == mk.size() - 1));
            if (inject) begin
                in_valid = 1'b1;
                in_key   = KEY_W'(guard);
                in_val   = 32'hDEAD_0000 + guard;
            end
            out_ready = (stall_every == 0) || ((guard % stall_every) != 0);
            if (out_ready) begin
                if (idx == mk.size() - 1) done = 1'b1;
                idx++;
            end
            guard++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        in_valid  = 1'b0;
        check(done, req, "drain completed", done, 1);
        check(!draining && !out_valid, "R8", "idle after final entry", {draining, out_valid}, 0);
        check(!full && in_ready, "R8", "empty and ready after drain", {full, in_ready}, 1);
        mk.delete();
        mv.delete();
    endtask

    // Flush with nothing stored: no output, one drain cycle, then ready.
    task automatic empty_flush(input string req);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check(draining === 1'b1, req, "one drain cycle on empty flush", draining, 1);
        check(out_valid === 1'b0, req, "no output on empty flush", out_valid, 0);
        @(negedge clk);
        check(draining === 1'b0 && in_ready === 1'b1, req, "ready after empty flush",
              {draining, in_ready}, 2'b01);
        check(out_valid === 1'b0, req, "still no output", out_valid, 0);
    endtask

    task automatic t_reset();
        check(!full && !out_valid && !draining && in_ready, "R1", "reset state",
              {full, out_valid, draining, in_ready}, 4'b0001);
        empty_flush("R9");
    endtask

    // Descending keys: every arrival lands in slot 0; back-to-back (R3).
    task automatic t_descending();
        for (int i = 0; i < 8; i++) push(KEY_W'(100 - 10 * i), 32'h100 + i, "R3");
        drain_expect(0, 1'b0, "R2");
    endtask

    // Scrambled keys with many repeats; checks stable order (R4) under stalls.
    task automatic t_duplicates();
        for (int i = 0; i < 20; i++) push(KEY_W'((i * 7 + 3) % 5), 32'h200 + i, "R4");
        drain_expect(3, 1'b0, "R4");
    endtask

    // Fill to capacity with extreme keys, then offer more while full (R5).
    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) begin
            logic [KEY_W-1:0] k;
            if (i == 5)       k = '1;
            else if (i == 9)  k = '0;
            else              k = KEY_W'((i * 13 + 40) % 97);
            push(k, 32'h300 + i, "R2");
        end
        check(full === 1'b1 && in_ready === 1'b0, "R5", "full flag at capacity",
              {full, in_ready}, 2'b10);
        in_valid = 1'b1;
        in_key   = '0;
        in_val   = 32'hBAD0_0001;
        repeat (3) begin
            @(negedge clk);
            check(in_ready === 1'b0, "R5", "in_ready while full", in_ready, 0);
        end
        in_valid = 1'b0;
        drain_expect(4, 1'b0, "R5");
    endtask

    // Items offered during the drain must not enter (R7); then R8.
    task automatic t_drain_inject();
        for (int i = 0; i < 6; i++) push(KEY_W'(50 + (i % 3)), 32'h400 + i, "R3");
        drain_expect(2, 1'b1, "R7");
        empty_flush("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_descending();
        t_duplicates();
        t_full();
        t_drain_inject();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule